// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block controls an external dual-slope integrating converter. It drives a two-bit phase code to the analog front end and watches one asynchronous comparator input. The comparator tells the block the sign of the integrated signal and marks the end of the reference ramp. While idle, the block holds the front end in auto zero. A start request begins a conversion, which then runs through four phases: auto zero, signal integrate, reference de-integrate and integrator output zero. The block then returns to auto zero and waits there.

The length of the integrate phase is given in clock counts and latched when the start request is accepted. The auto zero time that opens each conversion has the same length. The de-integrate time is measured in clock counts and ends on the first falling edge of the comparator. The block reports that time as a sign-and-magnitude result with an overrange flag and a one-cycle valid strobe. An analog channel code is latched with the start request and held for the whole conversion.

Top module: `dsc_sequencer`

## Requirements
- R1: Phase code encoding: 00 is integrator output zero, 01 is auto zero, 10 is signal integrate and 11 is reference de-integrate. Out of reset the code is 01, the valid strobe is 0 and the channel output is 0.
- R2: Phase changes follow only the sequence 01, 10, 11, 00, 01.
- R3: The block stays at 01 indefinitely while no start is requested. When a start is accepted, the block first spends N more cycles in 01 and then N cycles in 10. N is `int_len_i` latched at the start; values below 2 count as 2.
- R4: The comparator is ignored in auto zero and early in integrate. Polarity is taken once, from the synchronized comparator level in the last integrate cycle. `res_neg_o` is 0 when that level is high and 1 when it is low.
- R5: Code 11 follows the last integrate cycle directly, with no cycle in between.
- R6: Cycle 0 of de-integrate is the first cycle with code 11. If `cmp_i` falls between cycle j and cycle j+1 of de-integrate, the magnitude is j: the two-cycle synchronizer delay is removed. Code 11 is held through cycle j+2.
- R7: If no falling edge is seen by de-integrate cycle 2N-1, the phase ends after that cycle. `res_ovr_o` is then 1 and the magnitude is 2N. The last input fall that still gives a normal result is at j = 2N-3.
- R8: Code 00 is held after de-integrate until the synchronized comparator is high. The block then moves to 01 on the very next edge, so 01 appears exactly three cycles after `cmp_i` rises.
- R9: `res_valid_o` is high for exactly one cycle, the first cycle of code 00. The result outputs then hold their values until the next conversion.
- R10: A start request during a conversion is ignored. `chan_o` takes `chan_i` at the accepted start and ignores later changes of `chan_i` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| chan_i | input | CH_W | Channel code to latch at start |
| int_len_i | input | CNT_W | Integrate length N in clock counts |
| cmp_i | input | 1 | Asynchronous comparator level |
| phase_o | output | 2 | Phase code to the front end |
| chan_o | output | CH_W | Latched channel code |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_neg_o | output | 1 | Sign of the result, 1 for a negative input |
| res_ovr_o | output | 1 | De-integrate limit reached |
| res_mag_o | output | CNT_W+1 | De-integrate count after latency correction |

## Verification
Conversions are run with random integrate lengths, polarities, fall instants and zeroing delays. The comparator is randomized during auto zero and the early part of integrate, which shows that only the final integrate sample sets the sign. Directed cases cover the following boundaries:
- a fall in de-integrate cycle 0, which separates the latency correction from an off-by-one;
- falls at 2N-3 and 2N-2, which separate the last normal count from the first overrange;
- a comparator that never falls;
- a clamped length of 0;
- zeroing exit delays of zero and more cycles, which pin down the immediate return to auto zero.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZ,
    ST_INT,
    ST_DINT,
    ST_IZ
  } dsc_state_e;

  typedef enum logic [1:0] {
    PH_IZ   = 2'b00,
    PH_AZ   = 2'b01,
    PH_INT  = 2'b10,
    PH_DINT = 2'b11
  } dsc_phase_e;

  function automatic logic [1:0] phase_of(dsc_state_e s);
    case (s)
      ST_INT:  phase_of = PH_INT;
      ST_DINT: phase_of = PH_DINT;
      ST_IZ:   phase_of = PH_IZ;
      default: phase_of = PH_AZ;
    endcase
  endfunction

endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/dsc_cmp_sync.sv
module dsc_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= cmp_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
  import dsc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CH_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             cmp_lvl_i,
  input  logic             cmp_fall_i,
  output dsc_state_e       state_o,
  output logic [CNT_W:0]   cnt_o,
  output logic [CNT_W-1:0] len_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             pol_take_o,
  output logic             done_o,
  output logic             ovr_o
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

  dsc_state_e       state_q, state_d;
  logic [CNT_W:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q;
  logic [CH_W-1:0]  chan_q;
  logic             load;
  logic [CNT_W:0]   last_run, last_dint;

  assign last_run  = {1'b0, len_q} - 1'b1;
  assign last_dint = {len_q, 1'b0} - 1'b1;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    load       = 1'b0;
    pol_take_o = 1'b0;
    done_o     = 1'b0;
    ovr_o      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_AZ;
          cnt_d   = '0;
          load    = 1'b1;
        end
      end
      ST_AZ: begin
        if (cnt_q == last_run) begin
          state_d = ST_INT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_INT: begin
        if (cnt_q == last_run) begin
          state_d    = ST_DINT;
          cnt_d      = '0;
          pol_take_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DINT: begin
        if (cmp_fall_i) begin
          state_d = ST_IZ;
          done_o  = 1'b1;
        end else if (cnt_q == last_dint) begin
          state_d = ST_IZ;
          done_o  = 1'b1;
          ovr_o   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_IZ: begin
        if (cmp_lvl_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= MIN_LEN;
      chan_q <= '0;
    end else if (load) begin
      len_q  <= (len_i < MIN_LEN) ? MIN_LEN : len_i;
      chan_q <= chan_i;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign len_o   = len_q;
  assign chan_o  = chan_q;
endmodule

// File: rtl/dsc_capture.sv
module dsc_capture #(
  parameter int CNT_W = 16,
  parameter int LAT   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pol_take_i,
  input  logic             cmp_lvl_i,
  input  logic             done_i,
  input  logic             ovr_i,
  input  logic [CNT_W:0]   cnt_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             valid_o,
  output logic             neg_o,
  output logic             ovr_o,
  output logic [CNT_W:0]   mag_o
);
  localparam logic [CNT_W:0] LAT_CNT = (CNT_W+1)'(LAT);

  logic           pol_neg_q;
  logic           valid_q, neg_q, ovr_q;
  logic [CNT_W:0] mag_q, mag_d;

  always_comb begin
    if (ovr_i)                mag_d = {len_i, 1'b0};
    else if (cnt_i >= LAT_CNT) mag_d = cnt_i - LAT_CNT;
    else                      mag_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pol_neg_q <= 1'b0;
    else if (pol_take_i) pol_neg_q <= ~cmp_lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q <= 1'b0;
      ovr_q <= 1'b0;
      mag_q <= '0;
    end else if (done_i) begin
      neg_q <= pol_neg_q;
      ovr_q <= ovr_i;
      mag_q <= mag_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= done_i;
  end

  assign valid_o = valid_q;
  assign neg_o   = neg_q;
  assign ovr_o   = ovr_q;
  assign mag_o   = mag_q;
endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CH_W  = 2,
  parameter int SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [CNT_W-1:0] int_len_i,
  input  logic             cmp_i,
  output logic [1:0]       phase_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             res_valid_o,
  output logic             res_neg_o,
  output logic             res_ovr_o,
  output logic [CNT_W:0]   res_mag_o
);
  logic             rst_n_s;
  logic             lvl_w, fall_w;
  dsc_state_e       state_w;
  logic [CNT_W:0]   cnt_w;
  logic [CNT_W-1:0] len_w;
  logic             pol_take_w, done_w, ovr_w;

  dsc_rst_sync #(.STAGES(2)) i_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  dsc_cmp_sync #(.STAGES(SYNC)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .cmp_i (cmp_i),
    .lvl_o (lvl_w),
    .fall_o(fall_w)
  );

  dsc_fsm #(.CNT_W(CNT_W), .CH_W(CH_W)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .start_i   (start_i),
    .chan_i    (chan_i),
    .len_i     (int_len_i),
    .cmp_lvl_i (lvl_w),
    .cmp_fall_i(fall_w),
    .state_o   (state_w),
    .cnt_o     (cnt_w),
    .len_o     (len_w),
    .chan_o    (chan_o),
    .pol_take_o(pol_take_w),
    .done_o    (done_w),
    .ovr_o     (ovr_w)
  );

  dsc_capture #(.CNT_W(CNT_W), .LAT(SYNC)) i_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .pol_take_i(pol_take_w),
    .cmp_lvl_i (lvl_w),
    .done_i    (done_w),
    .ovr_i     (ovr_w),
    .cnt_i     (cnt_w),
    .len_i     (len_w),
    .valid_o   (res_valid_o),
    .neg_o     (res_neg_o),
    .ovr_o     (res_ovr_o),
    .mag_o     (res_mag_o)
  );

  assign phase_o = phase_of(state_w);
endmodule

// File: rtl/dsc_sequencer_chk.sv
module dsc_sequencer_chk
  import dsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       phase,
  input dsc_state_e       state,
  input logic [CNT_W:0]   cnt,
  input logic [CNT_W-1:0] len,
  input logic             cmp_lvl,
  input logic             valid,
  input logic             ovr,
  input logic [CNT_W:0]   mag
);
  logic [CNT_W:0] last_run;
  assign last_run = {1'b0, len} - 1'b1;

  // R2: each phase is entered only from its predecessor
  assert_order_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10 && $past(phase) != 2'b10) |-> $past(phase) == 2'b01);
  assert_order_dint_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && $past(phase) != 2'b11) |-> $past(phase) == 2'b10);
  assert_order_iz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && $past(phase) != 2'b00) |-> $past(phase) == 2'b11);
  assert_order_az_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b01 && $past(phase) != 2'b01) |-> $past(phase) == 2'b00);

  // R3: auto zero run ends into integrate after its count
  assert_az_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AZ && cnt == last_run) |=> phase == 2'b10);

  // R5: no gap between integrate and de-integrate
  assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INT && cnt == last_run) |=> phase == 2'b11);

  // R7: overrange reports full scale
  assert_ovr_mag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ovr) |-> mag == {len, 1'b0});

  // R8: zeroing ends on the edge after the comparator level is high
  assert_iz_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IZ && cmp_lvl) |=> phase == 2'b01);

  // R9: one-cycle strobe right after de-integrate
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_valid_after_dint_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(phase) == 2'b11 && phase == 2'b00));
endmodule

bind dsc_sequencer dsc_sequencer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk    (clk_i),
  .rst_n  (rst_n_s),
  .phase  (phase_o),
  .state  (state_w),
  .cnt    (cnt_w),
  .len    (len_w),
  .cmp_lvl(lvl_w),
  .valid  (res_valid_o),
  .ovr    (res_ovr_o),
  .mag    (res_mag_o)
);

// File: tb/test_dsc_sequencer.sv
`timescale 1ns/1ps
module test_dsc_sequencer;
  localparam int CNT_W = 16;
  localparam int CH_W  = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             start_i;
  logic [CH_W-1:0]  chan_i;
  logic [CNT_W-1:0] int_len_i;
  logic             cmp_i;
  logic [1:0]       phase_o;
  logic [CH_W-1:0]  chan_o;
  logic             res_valid_o, res_neg_o, res_ovr_o;
  logic [CNT_W:0]   res_mag_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  dsc_sequencer #(.CNT_W(CNT_W), .CH_W(CH_W)) i_dsc_sequencer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .chan_i(chan_i),
    .int_len_i(int_len_i), .cmp_i(cmp_i), .phase_o(phase_o), .chan_o(chan_o),
    .res_valid_o(res_valid_o), .res_neg_o(res_neg_o), .res_ovr_o(res_ovr_o),
    .res_mag_o(res_mag_o)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(int n);
    return (n < 2) ? 2 : n;
  endfunction

  function automatic longint exp_mag(int n, int j);
    return (j >= 2*n - 2) ? 2*n : j;
  endfunction

  task automatic idle_wait(int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_i);
      chk("R3", "idle phase", phase_o, 2'b01);
      chk("R9", "idle valid", res_valid_o, 0);
      cmp_i = 1'($urandom);
    end
  endtask

  // j: de-integrate cycle at which cmp_i falls; huge means never
  task automatic run_conv(int n_req, int ch, bit pos, int j, int iz_m, bit poke);
    int  n     = eff_len(n_req);
    bit  never = (j > 2*n - 2);
    bit  ovr   = (j >= 2*n - 2);
    int  last  = ovr ? 2*n - 1 : j + 2;
    int  exitz = never ? 1 : iz_m + 3;
    longint mag_e = exp_mag(n, j);
    @(negedge clk_i);
    start_i   = 1'b1;
    chan_i    = CH_W'(ch);
    int_len_i = CNT_W'(n_req);
    cmp_i     = 1'($urandom);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (k == 0) start_i = 1'b0;
      chk("R3", "auto zero phase", phase_o, 2'b01);
      cmp_i = 1'($urandom);                 // R4: ignored in auto zero
      if (k == 1) chan_i = ~CH_W'(ch);      // R10
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      chk("R3", "integrate phase", phase_o, 2'b10);
      chk("R10", "channel held", chan_o, ch);
      start_i = (poke && i == n/2);         // R10: ignored start
      cmp_i   = (i < n - 3) ? 1'($urandom) : pos;
    end
    for (int d = 0; d <= last; d++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      chk(d == 0 ? "R5" : "R6", "de-integrate phase", phase_o, 2'b11);
      cmp_i = never ? 1'b1 : (d < j);
    end
    @(negedge clk_i);
    chk("R8", "zeroing phase", phase_o, 2'b00);
    chk("R9", "valid strobe", res_valid_o, 1);
    chk(ovr ? "R7" : "R6", "magnitude", res_mag_o, mag_e);
    chk("R7", "overrange flag", res_ovr_o, ovr);
    chk("R4", "sign", res_neg_o, !pos);
    if (!never && iz_m == 0) cmp_i = 1'b1;
    for (int z = 1; z <= exitz; z++) begin
      @(negedge clk_i);
      if (z == 1) chk("R9", "valid drops", res_valid_o, 0);
      if (z < exitz) chk("R8", "zeroing held", phase_o, 2'b00);
      else           chk("R8", "return to auto zero", phase_o, 2'b01);
      if (!never && z == iz_m) cmp_i = 1'b1;
    end
    @(negedge clk_i);
    chk("R9", "magnitude held", res_mag_o, mag_e);
    chk("R9", "valid idle", res_valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; start_i = 1'b0; chan_i = '0; int_len_i = '0; cmp_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1", "reset phase", phase_o, 2'b01);
    chk("R1", "reset valid", res_valid_o, 0);
    chk("R1", "reset channel", chan_o, 0);
    rst_ni = 1'b1;
    idle_wait(6);

    run_conv(8, 1, 1'b1, 5, 2, 1'b1);
    run_conv(8, 2, 1'b0, 7, 0, 1'b0);
    run_conv(6, 3, 1'b1, 0, 1, 1'b0);        // R6 fall in cycle 0
    run_conv(6, 0, 1'b1, 9, 0, 1'b0);        // R7 last normal 2N-3
    run_conv(6, 1, 1'b0, 10, 0, 1'b0);       // R7 first overrange 2N-2
    run_conv(5, 2, 1'b1, 1000, 0, 1'b1);     // R7 no fall at all
    run_conv(0, 3, 1'b1, 0, 2, 1'b0);        // R3 clamp to 2
    idle_wait(20);                           // R3 indefinite idle

    for (int t = 0; t < 25; t++) begin
      int  n   = 4 + int'($urandom_range(36));
      bit  pos = 1'($urandom);
      int  j   = int'($urandom_range(2*n - 3, pos ? 0 : 1));
      run_conv(n, int'($urandom_range(3)), pos, j,
               int'($urandom_range(4)), 1'($urandom));
      idle_wait(int'($urandom_range(5)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule